// File: doc/BRIEF.md
# Three-Domain Clock Ratio Controller

The block derives three clock-enable strobes from a single input clock: one for the core, one for the peripherals and one for the external bus. Software sets a 3-bit ratio code for each domain with a single register write. The new codes do not take effect at once. They are held as a pending configuration until the external bus is idle. Then all three domains switch together, in one input-clock cycle, and a shared phase counter restarts so that the strobes stay aligned.

The core setting dominates. A peripheral or bus code that asks for a faster rate than the core is raised to the core's code, so neither domain can ever run ahead of the core strobe. The effective (clamped) codes are reported on their own output, apart from the raw readback of the last write. A range flag reports an effective rate that lies outside the allowed window for its domain at the configured input frequency.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: Field layout of `wr_data`, `rd_data` and `eff_ratio` is bits [2:0] core, bits [5:3] peripheral, bits [8:6] bus. Code c in 0..5 divides the input clock by 2^c. Codes 6 and 7 behave as code 5 (divide by 32).
- R2: `rd_data` returns the raw 9-bit value of the most recent write, starting one cycle after the write, with no clamping or normalisation.
- R3: The effective peripheral code is the larger of the normalised peripheral code and the normalised core code. Whenever `per_ce` is high, `core_ce` is high too.
- R4: The effective bus code is the larger of the normalised bus code and the normalised core code. Whenever `bus_ce` is high, `core_ce` is high too.
- R5: A write sets `upd_pending` in the next cycle. While `upd_pending` and `bus_busy` are both high, `eff_ratio` does not change.
- R6: In a cycle with `upd_pending` high, `bus_busy` low and `wr_en` low, the next cycle shows the clamped new codes on `eff_ratio` and `upd_pending` low. `eff_ratio` changes at no other time.
- R7: A write while an update is pending replaces the pending value, and only the last value is applied. A write in a cycle that would otherwise apply defers the apply to a later idle cycle.
- R8: A shared 5-bit phase counter increments every cycle and restarts at 0 in the cycle after an apply. A domain with effective code k strobes in every cycle in which the low k counter bits are all ones. Code 0 strobes every cycle.
- R9: `range_err` is high while any domain's effective rate, IN_KHZ / 2^code, falls outside its window: core 8000..50000 kHz, peripheral 8000..35000 kHz, bus 8000..50000 kHz. The default IN_KHZ is 50000.
- R10: After reset, the readback is 0, all effective codes are 0, no update is pending and the phase counter is 0, so all three strobes are high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Ratio register write strobe |
| wr_data | input | 9 | Ratio codes to write (bus, peripheral, core) |
| bus_busy | input | 1 | High while an external bus cycle is in progress |
| rd_data | output | 9 | Raw value of the last write |
| upd_pending | output | 1 | New codes are written but not yet applied |
| eff_ratio | output | 9 | Clamped effective codes in use |
| core_ce | output | 1 | Core clock-enable strobe |
| per_ce | output | 1 | Peripheral clock-enable strobe |
| bus_ce | output | 1 | External bus clock-enable strobe |
| range_err | output | 1 | Some effective rate lies outside its allowed window |

## Verification
The assertions assume that `bus_busy` is a level that the bus master holds for whole cycles and that it eventually drops. They also assume that `wr_en` is a single-cycle strobe whose data is valid in that same cycle. The stimulus drives every input on the falling edge and holds `bus_busy` only for bounded stretches, so each pending update can always apply. Some writes are placed in the very cycle an apply would have happened, and others are placed back to back under a busy bus. This exercises the ordering between a write and an apply in both directions.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned NDOM     = 3;
  localparam int unsigned MAX_CODE = 5;
  localparam int unsigned CNT_W    = MAX_CODE;
  localparam int unsigned CFG_W    = CODE_W * NDOM;

  typedef enum int unsigned {
    DOM_CORE = 0,
    DOM_PER  = 1,
    DOM_BUS  = 2
  } dom_e;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  phase_t;

  // Reserved codes saturate to the slowest legal ratio.
  function automatic code_t norm_code(input code_t c);
    return (c > code_t'(MAX_CODE)) ? code_t'(MAX_CODE) : c;
  endfunction

  // A subordinate domain never runs faster than the core domain.
  function automatic code_t clamp_to_core(input code_t req, input code_t core);
    code_t n;
    n = norm_code(req);
    return (n < core) ? core : n;
  endfunction

  // Strobe when the low 'code' bits of the phase counter are all ones.
  function automatic logic strobe_hit(input phase_t cnt, input code_t code);
    phase_t mask;
    mask = '0;
    for (int i = 0; i < int'(CNT_W); i++) begin
      if (i < int'(code)) mask[i] = 1'b1;
    end
    return (cnt & mask) == mask;
  endfunction

  function automatic logic freq_ok(input int unsigned in_khz, input code_t code,
                                   input int unsigned lo_khz, input int unsigned hi_khz);
    int unsigned f;
    f = in_khz >> code;
    return (f >= lo_khz) && (f <= hi_khz);
  endfunction
endpackage

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import clk_ratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             bus_busy,
  output logic [CFG_W-1:0] raw_q,
  output logic [CFG_W-1:0] eff_q,
  output logic             pend_q,
  output logic             apply_evt
);
  logic [CFG_W-1:0] eff_d;
  code_t            core_n;

  // An apply is only taken when the bus is idle and no new write competes.
  assign apply_evt = pend_q & ~bus_busy & ~wr_en;
  assign core_n    = norm_code(raw_q[DOM_CORE*CODE_W +: CODE_W]);

  always_comb begin
    eff_d = '0;
    eff_d[DOM_CORE*CODE_W +: CODE_W] = core_n;
    for (int d = 1; d < int'(NDOM); d++) begin
      eff_d[d*CODE_W +: CODE_W] = clamp_to_core(raw_q[d*CODE_W +: CODE_W], core_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
      eff_q  <= '0;
    end else begin
      if (wr_en) begin
        raw_q  <= wr_data;
        pend_q <= 1'b1;
      end else if (apply_evt) begin
        pend_q <= 1'b0;
      end
      if (apply_evt) eff_q <= eff_d;
    end
  end
endmodule

// File: rtl/clk_ratio_phase.sv
module clk_ratio_phase
  import clk_ratio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  output phase_t cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + phase_t'(1);
  end
endmodule

// File: rtl/clk_ratio_strobe.sv
module clk_ratio_strobe
  import clk_ratio_pkg::*;
(
  input  phase_t cnt,
  input  code_t  code,
  output logic   ce
);
  assign ce = strobe_hit(cnt, code);
endmodule

// File: rtl/clk_ratio_range.sv
module clk_ratio_range
  import clk_ratio_pkg::*;
#(
  parameter int unsigned IN_KHZ       = 50000,
  parameter int unsigned CORE_MIN_KHZ = 8000,
  parameter int unsigned CORE_MAX_KHZ = 50000,
  parameter int unsigned PER_MIN_KHZ  = 8000,
  parameter int unsigned PER_MAX_KHZ  = 35000,
  parameter int unsigned BUS_MIN_KHZ  = 8000,
  parameter int unsigned BUS_MAX_KHZ  = 50000
) (
  input  logic [CFG_W-1:0] eff,
  output logic [NDOM-1:0]  dom_err
);
  for (genvar d = 0; d < int'(NDOM); d++) begin : g_dom
    localparam int unsigned LO = (d == DOM_CORE) ? CORE_MIN_KHZ :
                                 (d == DOM_PER)  ? PER_MIN_KHZ  : BUS_MIN_KHZ;
    localparam int unsigned HI = (d == DOM_CORE) ? CORE_MAX_KHZ :
                                 (d == DOM_PER)  ? PER_MAX_KHZ  : BUS_MAX_KHZ;
    assign dom_err[d] = ~freq_ok(IN_KHZ, eff[d*CODE_W +: CODE_W], LO, HI);
  end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int unsigned IN_KHZ       = 50000,
  parameter int unsigned CORE_MIN_KHZ = 8000,
  parameter int unsigned CORE_MAX_KHZ = 50000,
  parameter int unsigned PER_MIN_KHZ  = 8000,
  parameter int unsigned PER_MAX_KHZ  = 35000,
  parameter int unsigned BUS_MIN_KHZ  = 8000,
  parameter int unsigned BUS_MAX_KHZ  = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic       bus_busy,
  output logic [8:0] rd_data,
  output logic       upd_pending,
  output logic [8:0] eff_ratio,
  output logic       core_ce,
  output logic       per_ce,
  output logic       bus_ce,
  output logic       range_err
);
  logic [CFG_W-1:0] raw_q;
  logic [CFG_W-1:0] eff_q;
  logic             pend_q;
  logic             apply_evt;
  phase_t           phase_cnt;
  logic [NDOM-1:0]  ce_vec;
  logic [NDOM-1:0]  dom_err;

  clk_ratio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .bus_busy  (bus_busy),
    .raw_q     (raw_q),
    .eff_q     (eff_q),
    .pend_q    (pend_q),
    .apply_evt (apply_evt)
  );

  clk_ratio_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (apply_evt),
    .cnt_q   (phase_cnt)
  );

  for (genvar d = 0; d < int'(NDOM); d++) begin : g_strobe
    clk_ratio_strobe u_strobe (
      .cnt  (phase_cnt),
      .code (eff_q[d*CODE_W +: CODE_W]),
      .ce   (ce_vec[d])
    );
  end

  clk_ratio_range #(
    .IN_KHZ       (IN_KHZ),
    .CORE_MIN_KHZ (CORE_MIN_KHZ),
    .CORE_MAX_KHZ (CORE_MAX_KHZ),
    .PER_MIN_KHZ  (PER_MIN_KHZ),
    .PER_MAX_KHZ  (PER_MAX_KHZ),
    .BUS_MIN_KHZ  (BUS_MIN_KHZ),
    .BUS_MAX_KHZ  (BUS_MAX_KHZ)
  ) u_range (
    .eff     (eff_q),
    .dom_err (dom_err)
  );

  assign rd_data     = raw_q;
  assign upd_pending = pend_q;
  assign eff_ratio   = eff_q;
  assign core_ce     = ce_vec[DOM_CORE];
  assign per_ce      = ce_vec[DOM_PER];
  assign bus_ce      = ce_vec[DOM_BUS];
  assign range_err   = |dom_err;
endmodule

// File: rtl/clk_ratio_sva.sv
module clk_ratio_sva
  import clk_ratio_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       bus_busy,
  input logic       upd_pending,
  input logic [8:0] eff_ratio,
  input logic       core_ce,
  input logic       per_ce,
  input logic       bus_ce,
  input logic       apply_evt,
  input phase_t     phase_cnt
);
  AST_PER_WITHIN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ce |-> core_ce); // R3
  AST_BUS_WITHIN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce |-> core_ce); // R4
  AST_EFF_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_ratio[5:3] >= eff_ratio[2:0]) && (eff_ratio[8:6] >= eff_ratio[2:0]) &&
    (eff_ratio[2:0] <= 3'd5) && (eff_ratio[5:3] <= 3'd5) && (eff_ratio[8:6] <= 3'd5)); // R1
  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> upd_pending); // R5
  AST_HOLD_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && bus_busy) |=> $stable(eff_ratio)); // R5
  AST_APPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> !upd_pending); // R6
  AST_EFF_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pending |=> $stable(eff_ratio)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && wr_en) |=> (upd_pending && $stable(eff_ratio))); // R7
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (phase_cnt == '0)); // R8
endmodule

bind clk_ratio_ctrl clk_ratio_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .bus_busy    (bus_busy),
  .upd_pending (upd_pending),
  .eff_ratio   (eff_ratio),
  .core_ce     (core_ce),
  .per_ce      (per_ce),
  .bus_ce      (bus_ce),
  .apply_evt   (apply_evt),
  .phase_cnt   (phase_cnt)
);

// File: tb/sim_clk_ratio_ctrl.sv
module sim_clk_ratio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       bus_busy = 1'b0;
  logic [8:0] rd_data;
  logic       upd_pending;
  logic [8:0] eff_ratio;
  logic       core_ce, per_ce, bus_ce, range_err;

  always #5 clk = ~clk;

  clk_ratio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .bus_busy(bus_busy),
    .rd_data(rd_data), .upd_pending(upd_pending), .eff_ratio(eff_ratio),
    .core_ce(core_ce), .per_ce(per_ce), .bus_ce(bus_ce), .range_err(range_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference arithmetic, stated in divisors rather than codes.
  function automatic int div_of(input logic [2:0] c);
    return 1 << ((c > 3'd5) ? 5 : int'(c));
  endfunction

  function automatic logic [8:0] eff_of(input logic [8:0] raw);
    int dc, dp, db;
    dc = div_of(raw[2:0]);
    dp = div_of(raw[5:3]); if (dp < dc) dp = dc;
    db = div_of(raw[8:6]); if (db < dc) db = dc;
    return {3'($clog2(db)), 3'($clog2(dp)), 3'($clog2(dc))};
  endfunction

  function automatic bit rate_bad(input logic [2:0] code, input int hi);
    int f;
    f = 50000 / (1 << int'(code));
    return (f < 8000) || (f > hi);
  endfunction

  // Cycle model built from the requirements.
  logic [8:0] m_raw, m_eff;
  logic       m_pend;
  logic [4:0] m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw <= '0; m_eff <= '0; m_pend <= 1'b0; m_cnt <= '0;
    end else begin
      if (wr_en) begin
        m_raw <= wr_data; m_pend <= 1'b1; m_cnt <= m_cnt + 5'd1;
      end else if (m_pend && !bus_busy) begin
        m_eff <= eff_of(m_raw); m_pend <= 1'b0; m_cnt <= '0;
      end else begin
        m_cnt <= m_cnt + 5'd1;
      end
    end
  end

  // Monitor: per-cycle compare plus scoreboard pop on each completed update.
  logic prev_pend = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      int dc, dp, db;
      logic [8:0] e;
      dc = 1 << int'(m_eff[2:0]);
      dp = 1 << int'(m_eff[5:3]);
      db = 1 << int'(m_eff[8:6]);
      chk(eff_ratio == m_eff, "R1 R3 R4 eff_ratio", eff_ratio, m_eff);
      chk(rd_data == m_raw, "R2 rd_data", rd_data, m_raw);
      chk(upd_pending == m_pend, "R5 R6 R7 upd_pending", upd_pending, m_pend);
      chk(core_ce == ((int'(m_cnt) % dc) == dc - 1), "R8 core_ce", core_ce, (int'(m_cnt) % dc) == dc - 1);
      chk(per_ce == ((int'(m_cnt) % dp) == dp - 1), "R8 per_ce", per_ce, (int'(m_cnt) % dp) == dp - 1);
      chk(bus_ce == ((int'(m_cnt) % db) == db - 1), "R8 bus_ce", bus_ce, (int'(m_cnt) % db) == db - 1);
      chk(range_err == (rate_bad(m_eff[2:0], 50000) || rate_bad(m_eff[5:3], 35000) ||
                        rate_bad(m_eff[8:6], 50000)), "R9 range_err", range_err,
          rate_bad(m_eff[2:0], 50000) || rate_bad(m_eff[5:3], 35000) || rate_bad(m_eff[8:6], 50000));
      if (prev_pend && !upd_pending) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected apply", eff_ratio, 0);
        else begin
          e = exp_q.pop_front();
          chk(eff_ratio == e, "R6 R7 applied codes", eff_ratio, e);
        end
      end
    end
    prev_pend = upd_pending;
  end

  // Driver tasks; every call starts and ends just after a falling edge.
  task automatic push_exp(input logic [8:0] raw);
    exp_q.push_back(eff_of(raw));
  endtask

  task automatic wr(input logic [8:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    // R10 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 9'h0, "R10 readback", rd_data, 0);
    chk(eff_ratio == 9'h0, "R10 eff", eff_ratio, 0);
    chk(upd_pending == 1'b0, "R10 pending", upd_pending, 0);
    chk(core_ce && per_ce && bus_ce, "R10 strobes", {core_ce, per_ce, bus_ce}, 7);
    chk(range_err == 1'b1, "R9 reset peripheral too fast", range_err, 1);
    mon_on = 1'b1;

    // Plain update with idle bus: core/2, peripheral/4, bus/2
    push_exp({3'd1, 3'd2, 3'd1}); wr({3'd1, 3'd2, 3'd1}); idle(40);
    chk(eff_ratio == 9'o121, "R6 plain update", eff_ratio, 9'o121);

    // R5 hold while the bus is busy
    bus_busy = 1'b1;
    push_exp({3'd0, 3'd1, 3'd0}); wr({3'd0, 3'd1, 3'd0}); idle(6);
    chk(eff_ratio == 9'o121 && upd_pending, "R5 held under busy", eff_ratio, 9'o121);
    bus_busy = 1'b0; idle(40);

    // R3 R4 clamp: core/4 with faster peripheral and bus requests
    push_exp({3'd1, 3'd0, 3'd2}); wr({3'd1, 3'd0, 3'd2}); idle(40);
    chk(eff_ratio == 9'o222, "R3 R4 clamped to core", eff_ratio, 9'o222);
    chk(rd_data == 9'o102, "R2 raw readback", rd_data, 9'o102);

    // R1 reserved codes saturate
    push_exp({3'd3, 3'd7, 3'd6}); wr({3'd3, 3'd7, 3'd6}); idle(70);
    chk(eff_ratio == 9'o555, "R1 reserved codes", eff_ratio, 9'o555);

    // R7 replacement under busy
    bus_busy = 1'b1;
    wr({3'd4, 3'd4, 3'd4});
    push_exp({3'd0, 3'd2, 3'd1}); wr({3'd0, 3'd2, 3'd1}); idle(3);
    bus_busy = 1'b0; idle(40);
    chk(eff_ratio == 9'o121, "R7 last write wins", eff_ratio, 9'o121);

    // R7 write in the cycle an apply would happen
    wr({3'd2, 3'd2, 3'd2});
    push_exp({3'd1, 3'd1, 3'd1}); wr({3'd1, 3'd1, 3'd1}); idle(40);
    chk(eff_ratio == 9'o111, "R7 deferred apply", eff_ratio, 9'o111);

    // R9 boundaries: core/8 too slow; core/1 peripheral/2 bus/1 legal
    push_exp({3'd3, 3'd3, 3'd3}); wr({3'd3, 3'd3, 3'd3}); idle(40);
    chk(range_err == 1'b1, "R9 below minimum", range_err, 1);
    push_exp({3'd0, 3'd1, 3'd0}); wr({3'd0, 3'd1, 3'd0}); idle(40);
    chk(range_err == 1'b0, "R9 legal setting", range_err, 0);

    chk(exp_q.size() == 0, "R6 all updates applied", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule